// File: doc/BRIEF.md
# Hypervisor coprocessor trap controller

This block holds the 32-bit trap-control register that a hypervisor uses to decide how lower levels reach the floating-point coprocessors (here called FP-A and FP-B), the SIMD unit and the OS-level coprocessor access-control register. Software reads and writes the register over a small CSR port. That port is gated by the requester's exception level and security state.

Beside the register sits a combinational judge. Each access query gives a level, a security state, a target resource and an OS-level permission flag. The judge answers with exactly one of three verdicts in the same cycle:
- allow,
- trap to the hypervisor,
- undefined-instruction.

Three side inputs come from the secure-side access controls: an FP-A enable, an FP-B enable and a SIMD disable. When the secure side denies a resource, the matching trap bit reads as one for non-secure requesters.

Top module: `hvt_trap_ctl`

## Requirements
- R1: After reset every writable trap bit is 0, `csr_rdata` and `csr_fault` are 0, and a permitted read returns 0x000033FF while the side inputs grant everything.
- R2: Only bits 31, 15, 11 and 10 are writable. Bits 13:12 and 9:0 always read 1. All other bits, including bit 20, always read 0, so writing all ones reads back 0x8000BFFF.
- R3: A read shows bit 10 as 1 while `sec_fpa_en` is 0, bit 11 as 1 while `sec_fpb_en` is 0, and bit 15 as 1 while `sec_simd_off` is 1. The stored bits are not altered, so restoring the side inputs restores the stored view.
- R4: A CSR access is permitted only when `csr_ns` is 1 and `csr_lvl` is 2 or 3. Any other access changes no state, returns 0 on `csr_rdata` and raises `csr_fault`.
- R5: `csr_rdata` and `csr_fault` are registered and appear one cycle after the request. Each lasts one cycle only, and both are 0 in cycles with no request.
- R6: A query with `q_ns` 0, or with `q_lvl` 3, is always allowed.
- R7: Resource code 0 (the access-control register) from non-secure level 1 traps when bit 31 is 1 and is allowed otherwise. From level 0 it is undefined. From level 2 it is allowed.
- R8: For resource codes 1 (FP-A, bit 10) and 2 (FP-B, bit 11), a set trap bit gives a trap for non-secure level 0 or 1 and undefined for level 2. The hypervisor is never trapped.
- R9: A non-secure query below level 3 is undefined when the secure side denies the resource. FP-A needs `sec_fpa_en`, FP-B needs `sec_fpb_en`, and SIMD (code 3) needs both.
- R10: For codes 1 to 3, a non-secure level 0 or 1 query with `q_os_ok` 0 is undefined. At level 2, `q_os_ok` has no effect.
- R11: `sec_simd_off` at 1 makes SIMD queries behave as if bit 15 were set: trap from level 0 or 1, undefined from level 2.
- R12: With both bit 10 and bit 11 set, SIMD queries trap from level 0 or 1 and are undefined from level 2, whatever bit 15 holds.
- R13: When `q_valid` is 1, exactly one of `q_allow`, `q_trap` and `q_undef` is 1, and all three are 0 otherwise. A register write affects verdicts from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR request strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_lvl | input | 2 | Exception level of the CSR requester |
| csr_ns | input | 1 | CSR requester is non-secure |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, one cycle after the request |
| csr_fault | output | 1 | Denied-access pulse, one cycle after the request |
| sec_fpa_en | input | 1 | Secure side grants FP-A to non-secure code |
| sec_fpb_en | input | 1 | Secure side grants FP-B to non-secure code |
| sec_simd_off | input | 1 | Secure side disables non-secure SIMD |
| q_valid | input | 1 | Query present |
| q_lvl | input | 2 | Exception level of the query |
| q_ns | input | 1 | Query is non-secure |
| q_res | input | 2 | Target: 0 ACR, 1 FP-A, 2 FP-B, 3 SIMD |
| q_os_ok | input | 1 | OS-level controls permit the access |
| q_allow | output | 1 | Verdict: allow |
| q_trap | output | 1 | Verdict: trap to hypervisor |
| q_undef | output | 1 | Verdict: undefined instruction |

## Verification
Several properties are checked on every cycle:
- the verdicts are one-hot or idle,
- secure and level-3 queries are allowed,
- the hypervisor is never trapped, and both FP bits force a SIMD trap,
- a fault carries zero data and leaves the stored bits unchanged,
- reads always show the fixed ones and any forced bits.

Only the bench scenarios can show the rest:
- exact read values after writes,
- that a write takes effect the following cycle,
- that forced bits vanish once the secure side grants access again,
- the ordering between secure denial, OS-level denial and trap bits for each resource and level.

// File: rtl/hvt_pkg.sv
package hvt_pkg;

   typedef enum logic [1:0] {
      LVL_APP = 2'd0,
      LVL_OS  = 2'd1,
      LVL_HYP = 2'd2,
      LVL_MON = 2'd3
   } hvt_lvl_e;

   typedef enum logic [1:0] {
      RES_ACR  = 2'd0,
      RES_FPA  = 2'd1,
      RES_FPB  = 2'd2,
      RES_SIMD = 2'd3
   } hvt_res_e;

   // one bit per writable trap control
   typedef struct packed {
      logic acr;
      logic simd;
      logic fpb;
      logic fpa;
   } hvt_traps_t;

   localparam int NUM_TRAPS = 4;

endpackage

// File: rtl/hvt_store.sv
module hvt_store
   import hvt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BIT_ACR  = 31,
   parameter int BIT_SIMD = 15,
   parameter int BIT_FPB  = 11,
   parameter int BIT_FPA  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [DATA_W-1:0] wdata,
   output hvt_traps_t        traps
);

   localparam int POS [NUM_TRAPS] = '{BIT_FPA, BIT_FPB, BIT_SIMD, BIT_ACR};

   logic [NUM_TRAPS-1:0] bit_q;

   for (genvar g = 0; g < NUM_TRAPS; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q[g] <= 1'b0;
         end else if (wr_go) begin
            bit_q[g] <= wdata[POS[g]];
         end
      end
   end

   assign traps = hvt_traps_t'(bit_q);

   logic unused_wbits;
   assign unused_wbits = ^wdata;

endmodule

// File: rtl/hvt_view.sv
module hvt_view
   import hvt_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                BIT_ACR  = 31,
   parameter int                BIT_SIMD = 15,
   parameter int                BIT_FPB  = 11,
   parameter int                BIT_FPA  = 10,
   parameter logic [DATA_W-1:0] ONE_MASK = 32'h0000_33FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_en,
   input  logic              csr_we,
   input  logic [1:0]        csr_lvl,
   input  logic              csr_ns,
   input  logic              sec_fpa_en,
   input  logic              sec_fpb_en,
   input  logic              sec_simd_off,
   input  hvt_traps_t        traps,
   output hvt_traps_t        eff,
   output logic              wr_go,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              csr_fault
);

   logic              permit;
   logic [DATA_W-1:0] rd_vec;
   logic [DATA_W-1:0] rdata_q;
   logic              fault_q;

   // only non-secure code at hypervisor level or above may touch the register
   assign permit = csr_ns && (hvt_lvl_e'(csr_lvl) inside {LVL_HYP, LVL_MON});
   assign wr_go  = csr_en && csr_we && permit;

   // non-secure view: secure-side denial forces the matching bit to one
   always_comb begin
      eff.acr  = traps.acr;
      eff.simd = traps.simd | sec_simd_off;
      eff.fpb  = traps.fpb  | ~sec_fpb_en;
      eff.fpa  = traps.fpa  | ~sec_fpa_en;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_rd
      if (ONE_MASK[b]) begin : g_one
         assign rd_vec[b] = 1'b1;
      end else if (b == BIT_ACR) begin : g_acr
         assign rd_vec[b] = eff.acr;
      end else if (b == BIT_SIMD) begin : g_simd
         assign rd_vec[b] = eff.simd;
      end else if (b == BIT_FPB) begin : g_fpb
         assign rd_vec[b] = eff.fpb;
      end else if (b == BIT_FPA) begin : g_fpa
         assign rd_vec[b] = eff.fpa;
      end else begin : g_zero
         assign rd_vec[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         fault_q <= 1'b0;
      end else begin
         rdata_q <= (csr_en && !csr_we && permit) ? rd_vec : '0;
         fault_q <= csr_en && !permit;
      end
   end

   assign csr_rdata = rdata_q;
   assign csr_fault = fault_q;

   // R4: a denied access never returns data
   p_fault_no_data_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      csr_fault |-> (csr_rdata == '0));

   // R5: a fault answers a request made in the previous cycle
   p_fault_cause_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      csr_fault |-> $past(csr_en));

   // R2: fixed ones are always present in returned data
   p_rsvd_ones_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata != '0) |-> ((csr_rdata & ONE_MASK) == ONE_MASK));

   // R3: a denied FP-A grant shows as a set bit
   p_forced_fpa_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_rdata != '0) && !$past(sec_fpa_en)) |-> csr_rdata[BIT_FPA]);

endmodule

// File: rtl/hvt_judge.sv
module hvt_judge
   import hvt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       q_valid,
   input  logic [1:0] q_lvl,
   input  logic       q_ns,
   input  logic [1:0] q_res,
   input  logic       q_os_ok,
   input  logic       sec_fpa_en,
   input  logic       sec_fpb_en,
   input  hvt_traps_t eff,
   output logic       q_allow,
   output logic       q_trap,
   output logic       q_undef
);

   hvt_lvl_e lvl;
   hvt_res_e res;
   logic     sec_deny;
   logic     trap_bit;
   logic     below_hyp;

   assign lvl       = hvt_lvl_e'(q_lvl);
   assign res       = hvt_res_e'(q_res);
   assign below_hyp = (lvl == LVL_APP) || (lvl == LVL_OS);

   always_comb begin
      unique case (res)
         RES_FPA:  begin sec_deny = ~sec_fpa_en;               trap_bit = eff.fpa; end
         RES_FPB:  begin sec_deny = ~sec_fpb_en;               trap_bit = eff.fpb; end
         RES_SIMD: begin sec_deny = ~(sec_fpa_en & sec_fpb_en);
                         trap_bit = eff.simd | (eff.fpa & eff.fpb); end
         default:  begin sec_deny = 1'b0;                      trap_bit = eff.acr; end
      endcase
   end

   always_comb begin
      q_allow = 1'b0;
      q_trap  = 1'b0;
      q_undef = 1'b0;
      if (!q_valid) begin
         q_allow = 1'b0;
      end else if (!q_ns || lvl == LVL_MON) begin
         q_allow = 1'b1;
      end else if (res == RES_ACR) begin
         if (lvl == LVL_APP)               q_undef = 1'b1;
         else if (lvl == LVL_OS && trap_bit) q_trap = 1'b1;
         else                              q_allow = 1'b1;
      end else if (sec_deny) begin
         q_undef = 1'b1;
      end else if (below_hyp && !q_os_ok) begin
         q_undef = 1'b1;
      end else if (trap_bit) begin
         if (below_hyp) q_trap  = 1'b1;
         else           q_undef = 1'b1;
      end else begin
         q_allow = 1'b1;
      end
   end

   // R13: one verdict per valid query, none otherwise
   p_onehot_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ($countones({q_allow, q_trap, q_undef}) == 1));
   p_idle_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> ({q_allow, q_trap, q_undef} == 3'b000));

   // R6: secure requesters and level 3 pass untouched
   p_secure_allow_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && (!q_ns || q_lvl == 2'd3)) |-> q_allow);

   // R8: the hypervisor itself is never trapped
   p_hyp_no_trap_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_lvl == 2'd2) |-> !q_trap);

   // R12: both FP trap bits catch SIMD use from lower levels
   p_both_fp_simd_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_ns && q_lvl < 2'd2 && q_res == 2'd3 && q_os_ok &&
       sec_fpa_en && sec_fpb_en && eff.fpa && eff.fpb) |-> q_trap);

endmodule

// File: rtl/hvt_trap_ctl.sv
module hvt_trap_ctl
   import hvt_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                BIT_ACR  = 31,
   parameter int                BIT_SIMD = 15,
   parameter int                BIT_FPB  = 11,
   parameter int                BIT_FPA  = 10,
   parameter logic [DATA_W-1:0] ONE_MASK = 32'h0000_33FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_en,
   input  logic              csr_we,
   input  logic [1:0]        csr_lvl,
   input  logic              csr_ns,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              csr_fault,
   input  logic              sec_fpa_en,
   input  logic              sec_fpb_en,
   input  logic              sec_simd_off,
   input  logic              q_valid,
   input  logic [1:0]        q_lvl,
   input  logic              q_ns,
   input  logic [1:0]        q_res,
   input  logic              q_os_ok,
   output logic              q_allow,
   output logic              q_trap,
   output logic              q_undef
);

   localparam logic [DATA_W-1:0] ONE_BIT    = {{(DATA_W-1){1'b0}}, 1'b1};
   localparam logic [DATA_W-1:0] FIELD_MASK = (ONE_BIT << BIT_ACR) | (ONE_BIT << BIT_SIMD) |
                                              (ONE_BIT << BIT_FPB) | (ONE_BIT << BIT_FPA);

   if (BIT_ACR >= DATA_W || BIT_SIMD >= DATA_W || BIT_FPB >= DATA_W || BIT_FPA >= DATA_W) begin : g_bad_pos
      $error("trap field position outside the register");
   end
   if ($countones(FIELD_MASK) != NUM_TRAPS) begin : g_bad_dup
      $error("trap field positions overlap");
   end
   if ((FIELD_MASK & ONE_MASK) != '0) begin : g_bad_mask
      $error("fixed-one mask covers a trap field");
   end

   hvt_traps_t traps;
   hvt_traps_t eff;
   logic       wr_go;

   hvt_view #(
      .DATA_W(DATA_W), .BIT_ACR(BIT_ACR), .BIT_SIMD(BIT_SIMD),
      .BIT_FPB(BIT_FPB), .BIT_FPA(BIT_FPA), .ONE_MASK(ONE_MASK)
   ) u_view (
      .clk(clk), .rst_n(rst_n),
      .csr_en(csr_en), .csr_we(csr_we), .csr_lvl(csr_lvl), .csr_ns(csr_ns),
      .sec_fpa_en(sec_fpa_en), .sec_fpb_en(sec_fpb_en), .sec_simd_off(sec_simd_off),
      .traps(traps), .eff(eff), .wr_go(wr_go),
      .csr_rdata(csr_rdata), .csr_fault(csr_fault)
   );

   hvt_store #(
      .DATA_W(DATA_W), .BIT_ACR(BIT_ACR), .BIT_SIMD(BIT_SIMD),
      .BIT_FPB(BIT_FPB), .BIT_FPA(BIT_FPA)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wdata(csr_wdata), .traps(traps)
   );

   hvt_judge u_judge (
      .clk(clk), .rst_n(rst_n),
      .q_valid(q_valid), .q_lvl(q_lvl), .q_ns(q_ns), .q_res(q_res), .q_os_ok(q_os_ok),
      .sec_fpa_en(sec_fpa_en), .sec_fpb_en(sec_fpb_en), .eff(eff),
      .q_allow(q_allow), .q_trap(q_trap), .q_undef(q_undef)
   );

   // R4: a denied access leaves the stored bits untouched
   p_fault_no_change_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      csr_fault |-> $stable(traps));

endmodule

// File: tb/hvt_trap_ctl_test.sv
module hvt_trap_ctl_test;

   localparam int T = 20;  // 50 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_en = 1'b0, csr_we = 1'b0, csr_ns = 1'b0;
   logic [1:0]  csr_lvl = 2'd0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        csr_fault;
   logic        sec_fpa_en = 1'b1, sec_fpb_en = 1'b1, sec_simd_off = 1'b0;
   logic        q_valid = 1'b0, q_ns = 1'b0, q_os_ok = 1'b1;
   logic [1:0]  q_lvl = 2'd0, q_res = 2'd0;
   logic        q_allow, q_trap, q_undef;

   always #(T/2) clk = ~clk;

   hvt_trap_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .csr_en(csr_en), .csr_we(csr_we), .csr_lvl(csr_lvl), .csr_ns(csr_ns),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_fault(csr_fault),
      .sec_fpa_en(sec_fpa_en), .sec_fpb_en(sec_fpb_en), .sec_simd_off(sec_simd_off),
      .q_valid(q_valid), .q_lvl(q_lvl), .q_ns(q_ns), .q_res(q_res), .q_os_ok(q_os_ok),
      .q_allow(q_allow), .q_trap(q_trap), .q_undef(q_undef)
   );

   typedef struct {
      int          due;
      bit          is_csr;
      logic [32:0] exp;
      string       tag;
   } item_t;

   item_t queue_q[$];
   int    ncnt = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   // bench model of the writable bits
   logic m_acr = 0, m_simd = 0, m_fpb = 0, m_fpa = 0;

   always @(posedge clk) ncnt++;

   function automatic logic [31:0] model_read();
      logic [31:0] v;
      v = 32'h0000_33FF;
      v[31] = m_acr;
      v[15] = m_simd | sec_simd_off;
      v[11] = m_fpb | ~sec_fpb_en;
      v[10] = m_fpa | ~sec_fpa_en;
      return v;
   endfunction

   // returns {allow, trap, undef}
   function automatic logic [2:0] model_dec(logic v, logic [1:0] lvl, logic ns,
                                            logic [1:0] res, logic ok);
      logic deny, tb, low;
      if (!v) return 3'b000;
      if (!ns || lvl == 2'd3) return 3'b100;
      low = (lvl < 2'd2);
      if (res == 2'd0) begin
         if (lvl == 2'd0) return 3'b001;
         if (lvl == 2'd1 && m_acr) return 3'b010;
         return 3'b100;
      end
      case (res)
         2'd1:    begin deny = !sec_fpa_en; tb = m_fpa; end
         2'd2:    begin deny = !sec_fpb_en; tb = m_fpb; end
         default: begin deny = !(sec_fpa_en && sec_fpb_en);
                        tb = m_simd | sec_simd_off | (m_fpa & m_fpb); end
      endcase
      if (deny) return 3'b001;
      if (low && !ok) return 3'b001;
      if (tb) return low ? 3'b010 : 3'b001;
      return 3'b100;
   endfunction

   task automatic csr_op(input bit we, input logic [1:0] lvl, input bit ns,
                         input logic [31:0] wd, input string tag);
      item_t it;
      bit ok;
      ok = ns && (lvl >= 2'd2);
      csr_en = 1'b1; csr_we = we; csr_lvl = lvl; csr_ns = ns; csr_wdata = wd;
      it.due = ncnt + 1; it.is_csr = 1'b1; it.tag = tag;
      it.exp = {!ok, (ok && !we) ? model_read() : 32'h0};
      queue_q.push_back(it);
      if (ok && we) begin
         m_acr = wd[31]; m_simd = wd[15]; m_fpb = wd[11]; m_fpa = wd[10];
      end
      @(negedge clk);
      csr_en = 1'b0; csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic csr_idle(input string tag);
      item_t it;
      it.due = ncnt + 1; it.is_csr = 1'b1; it.tag = tag; it.exp = '0;
      queue_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic query(input bit v, input logic [1:0] lvl, input bit ns,
                        input logic [1:0] res, input bit ok, input string tag);
      item_t it;
      q_valid = v; q_lvl = lvl; q_ns = ns; q_res = res; q_os_ok = ok;
      it.due = ncnt; it.is_csr = 1'b0; it.tag = tag;
      it.exp = {30'h0, model_dec(v, lvl, ns, res, ok)};
      queue_q.push_back(it);
      @(negedge clk);
      q_valid = 1'b0;
   endtask

   // monitor: compares results as they become due
   initial begin
      forever begin
         @(negedge clk);
         #5;
         while (queue_q.size() > 0 && queue_q[0].due <= ncnt) begin
            item_t it;
            logic [32:0] got;
            it = queue_q.pop_front();
            got = it.is_csr ? {csr_fault, csr_rdata} : {30'h0, q_allow, q_trap, q_undef};
            checks++;
            if (got !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      csr_idle("R1");
      query(0, 2'd1, 1, 2'd1, 1, "R1");
      csr_op(0, 2'd2, 1, 32'h0, "R1");
      // R2: reserved masking
      csr_op(1, 2'd2, 1, 32'hFFFF_FFFF, "R2");
      csr_op(0, 2'd2, 1, 32'h0, "R2");
      csr_op(1, 2'd3, 1, 32'h0, "R4");
      csr_op(0, 2'd3, 1, 32'h0, "R2");
      // R4: denied accesses
      csr_op(1, 2'd1, 1, 32'hFFFF_FFFF, "R4");
      csr_op(1, 2'd2, 0, 32'hFFFF_FFFF, "R4");
      csr_op(0, 2'd3, 0, 32'h0, "R4");
      csr_op(0, 2'd0, 1, 32'h0, "R4");
      csr_idle("R5");
      csr_op(0, 2'd2, 1, 32'h0, "R4");
      csr_idle("R5");
      // R3: forced-one view
      sec_fpa_en = 1'b0;
      csr_op(0, 2'd2, 1, 32'h0, "R3");
      sec_fpb_en = 1'b0;
      csr_op(0, 2'd2, 1, 32'h0, "R3");
      sec_simd_off = 1'b1;
      csr_op(0, 2'd2, 1, 32'h0, "R3");
      sec_fpa_en = 1'b1; sec_fpb_en = 1'b1; sec_simd_off = 1'b0;
      csr_op(0, 2'd2, 1, 32'h0, "R3");
      // R6 / R13 basics
      query(1, 2'd1, 0, 2'd1, 1, "R6");
      query(1, 2'd1, 1, 2'd1, 1, "R13");
      // R8: FP-A trap bit, effect from the next cycle
      csr_op(1, 2'd2, 1, 32'h0000_0400, "R8");
      query(1, 2'd1, 1, 2'd1, 1, "R13");
      query(1, 2'd0, 1, 2'd1, 1, "R8");
      query(1, 2'd2, 1, 2'd1, 1, "R8");
      query(1, 2'd1, 1, 2'd2, 1, "R8");
      query(1, 2'd1, 0, 2'd1, 1, "R6");
      query(1, 2'd3, 1, 2'd1, 1, "R6");
      // R10: OS-level denial
      query(1, 2'd1, 1, 2'd2, 0, "R10");
      query(1, 2'd2, 1, 2'd2, 0, "R10");
      // R9: secure-side denial
      sec_fpb_en = 1'b0;
      query(1, 2'd2, 1, 2'd2, 1, "R9");
      query(1, 2'd1, 1, 2'd3, 1, "R9");
      query(1, 2'd1, 0, 2'd2, 1, "R9");
      sec_fpb_en = 1'b1;
      // R11: SIMD disable
      query(1, 2'd1, 1, 2'd3, 1, "R11");
      sec_simd_off = 1'b1;
      query(1, 2'd1, 1, 2'd3, 1, "R11");
      query(1, 2'd2, 1, 2'd3, 1, "R11");
      sec_simd_off = 1'b0;
      // R12: both FP bits
      csr_op(1, 2'd2, 1, 32'h0000_0C00, "R12");
      query(1, 2'd1, 1, 2'd3, 1, "R12");
      query(1, 2'd2, 1, 2'd3, 1, "R12");
      csr_op(1, 2'd2, 1, 32'h0000_0800, "R12");
      query(1, 2'd0, 1, 2'd3, 1, "R12");
      // R7: access-control register
      csr_op(1, 2'd2, 1, 32'h8000_0000, "R7");
      query(1, 2'd1, 1, 2'd0, 1, "R7");
      query(1, 2'd0, 1, 2'd0, 1, "R7");
      query(1, 2'd2, 1, 2'd0, 1, "R7");
      csr_op(1, 2'd2, 1, 32'h0, "R7");
      query(1, 2'd1, 1, 2'd0, 1, "R7");
      query(0, 2'd1, 1, 2'd0, 1, "R13");
      repeat (3) @(negedge clk);
      if (queue_q.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL scoreboard: actual %0d pending expected 0", queue_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule